// File: doc/BRIEF.md
# Rotating Drum Word Access Sequencer

This block sits between a processor's execution logic and a word store that behaves like a rotating drum. The store is held in a synchronous RAM with one cycle of read latency. Every clock cycle counts as one word cycle. A free-running position counter records which word of a track is currently passing under the heads.

A client presents one request at a time. A request carries a 10-bit logical location, a read/write flag, a flag asking for a read at whatever word is passing now, and write data with a bit mask. The sequencer does the following:

- It relocates locations in the switchable half of the map through a working-store group register.
- It charges a fixed penalty whenever the track part of the location changes.
- It waits for the requested word to rotate under the heads.
- It performs the access. A write is done as a read of the old word followed by a merge.

A one-cycle done pulse returns the word that was read. A cycle counter and the position counter are brought out, so the latency of every access can be measured at the ports.

Top module: `drum_access_ctrl`

## Requirements
- R1: `word_pos` is a 5-bit counter. It is 0 during reset, advances by one on every clock and wraps from 31 to 0.
- R2: Absolute RAM address translation:
  - If bit 9 of the logical location is 1, the absolute address is `{ws, loc[8:0]}`, where `ws` is the 4-bit working-store group.
  - If bit 9 is 0, the absolute address is `loc` with its upper bits zero.
  - `ram_addr` is 13 bits wide.
- R3: Latency of a normal access, counted from the cycle in which `req_ack` is high (cycle t0, position p0):
  - The rotational wait is W = (loc[4:0] − (p0 + 1 + P)) mod 32, where P is the track penalty.
  - `done` is high in cycle t0 + 3 + P + W.
  - The RAM read is issued in the cycle in which `word_pos` equals loc[4:0].
- R4: A read with `req_special` = 1 takes no rotational wait (W = 0):
  - Its word position is replaced by the position under the heads when the wait begins, (p0 + 1 + P) mod 32.
  - For writes, `req_special` is ignored.
- R5: Track penalty:
  - P = 6 when loc[9:5] differs from bits 9:5 of the previously accepted location.
  - P = 0 when the two are the same.
  - The previous location is 0 after reset.
- R6: Masked write:
  - The stored word becomes (old & ~mask) | (wdata & mask).
  - The RAM write is issued in the cycle after the read of the old word, to the same address.
  - `rdata` returns the old word.
  - A zero mask leaves the word unchanged.
- R7: Reset state:
  - The working-store group is 1 and `word_pos` is 0.
  - `cycle_cnt` is 0.
  - `done`, `busy` and `req_ack` are 0.
- R8: Working-store loads:
  - A `ws_load` pulse updates the group register at the next edge, even while an access is in flight.
  - The in-flight access keeps the absolute address it latched when it was accepted.
  - Requests accepted later use the new group.
- R9: Request and completion handshake:
  - `req_ack` is high only in a cycle where `req_valid` is high and the block is idle.
  - The block handles one access at a time.
  - `done` is a one-cycle pulse, and `rdata` is valid while `done` is high.
- R10: `cycle_cnt` is 0 during reset and increases by one on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; hold until acknowledged |
| req_addr | input | 10 | Logical location: group bit, track, word |
| req_we | input | 1 | 1 = masked write, 0 = read |
| req_special | input | 1 | Read at the current head position |
| req_wdata | input | 32 | Write data |
| req_mask | input | 32 | Write bit enables |
| req_ack | output | 1 | Request accepted this cycle |
| ws_load | input | 1 | Load the working-store group |
| ws_value | input | 4 | New working-store group |
| done | output | 1 | Access complete, one cycle |
| rdata | output | 32 | Word read (old word on a write) |
| busy | output | 1 | Access in progress |
| word_pos | output | 5 | Word position under the heads |
| cycle_cnt | output | 32 | Free-running cycle count |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 13 | Absolute RAM address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after `ram_en` |

## Verification
The in-line properties watch the following on every cycle:
- An ordinary read reaches the RAM only when the position counter matches the wanted word.
- A special read is issued as soon as the wait starts.
- An address in the fixed group carries zero upper bits.
- A RAM write always follows a read of the same address.
- The acknowledge appears only when idle, and the done pulse lasts one cycle.

The exact latency arithmetic needs the directed scenarios, because it combines the penalty with the modular wait. The same holds for the merged contents seen on a later read-back, and for the moment at which a group change takes effect relative to an access in flight.

// File: rtl/drum_pkg.sv
`timescale 1ns/1ps
package drum_pkg;
    localparam int DATA_W     = 32;
    localparam int LOC_W      = 10;
    localparam int POS_W      = 5;
    localparam int WS_W       = 4;
    localparam int TRACK_W    = LOC_W - POS_W;
    localparam int ABS_W      = LOC_W - 1 + WS_W;
    localparam int SWITCH_CYC = 6;
    localparam int SW_CNT_W   = $clog2(SWITCH_CYC + 1);
    localparam int CNT_W      = 32;
    localparam logic [WS_W-1:0] WS_RESET = WS_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWITCH,
        ST_SEEK,
        ST_XFER
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [SW_CNT_W-1:0] sw_cnt;
        logic [TRACK_W-1:0]  prev_track;
        logic [ABS_W-1:0]    abs_addr;
        logic                we;
        logic                special;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   mask;
        logic [WS_W-1:0]     ws;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } seq_regs_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
    } clk_regs_t;
endpackage

// File: rtl/drum_word_clock.sv
`timescale 1ns/1ps
module drum_word_clock
    import drum_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] word_pos,
    output logic [CNT_W-1:0] cycle_cnt
);
    clk_regs_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.pos = c_q.pos + POS_W'(1);
        c_d.cnt = c_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_pos  = c_q.pos;
    assign cycle_cnt = c_q.cnt;

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_pos == '1) |=> (word_pos == '0)); // R1
endmodule

// File: rtl/drum_addr_map.sv
`timescale 1ns/1ps
module drum_addr_map
    import drum_pkg::*;
(
    input  logic [LOC_W-1:0] loc,
    input  logic [WS_W-1:0]  ws,
    output logic [ABS_W-1:0] abs_addr
);
    localparam int LOW_W = LOC_W - 1;

    always_comb begin
        if (loc[LOC_W-1]) abs_addr = {ws, loc[LOW_W-1:0]};
        else              abs_addr = {{WS_W{1'b0}}, loc[LOW_W-1:0]};
    end
endmodule

// File: rtl/drum_seq.sv
`timescale 1ns/1ps
module drum_seq
    import drum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LOC_W-1:0]  req_addr,
    input  logic              req_we,
    input  logic              req_special,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              req_ack,
    input  logic              ws_load,
    input  logic [WS_W-1:0]   ws_value,
    output logic [WS_W-1:0]   ws_cur,
    input  logic [ABS_W-1:0]  abs_in,
    input  logic [POS_W-1:0]  word_pos,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ABS_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    seq_regs_t r_d, r_q;
    logic [ABS_W-1:0]  seek_addr;
    logic              hit;
    logic [DATA_W-1:0] merged;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        req_ack   = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = r_q.abs_addr;
        ram_wdata = r_q.wdata;
        seek_addr = r_q.special ? {r_q.abs_addr[ABS_W-1:POS_W], word_pos} : r_q.abs_addr;
        hit       = r_q.special || (word_pos == r_q.abs_addr[POS_W-1:0]);
        merged    = (ram_rdata & ~r_q.mask) | (r_q.wdata & r_q.mask);

        if (ws_load) r_d.ws = ws_value;

        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    req_ack        = 1'b1;
                    r_d.abs_addr   = abs_in;
                    r_d.we         = req_we;
                    r_d.special    = req_special & ~req_we;
                    r_d.wdata      = req_wdata;
                    r_d.mask       = req_mask;
                    r_d.prev_track = req_addr[LOC_W-1:POS_W];
                    if (req_addr[LOC_W-1:POS_W] != r_q.prev_track) begin
                        r_d.st     = ST_SWITCH;
                        r_d.sw_cnt = SW_CNT_W'(SWITCH_CYC - 1);
                    end else begin
                        r_d.st     = ST_SEEK;
                    end
                end
            end
            ST_SWITCH: begin
                if (r_q.sw_cnt == '0) r_d.st = ST_SEEK;
                else                  r_d.sw_cnt = r_q.sw_cnt - SW_CNT_W'(1);
            end
            ST_SEEK: begin
                ram_addr = seek_addr;
                if (hit) begin
                    ram_en       = 1'b1;
                    r_d.abs_addr = seek_addr;
                    r_d.st       = ST_XFER;
                end
            end
            ST_XFER: begin
                r_d.done  = 1'b1;
                r_d.rdata = ram_rdata;
                if (r_q.we) begin
                    ram_en    = 1'b1;
                    ram_we    = 1'b1;
                    ram_wdata = merged;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ws <= WS_RESET;
        end else begin
            r_q    <= r_d;
        end
    end

    assign ws_cur = r_q.ws;
    assign done   = r_q.done;
    assign rdata  = r_q.rdata;
    assign busy   = (r_q.st != ST_IDLE);

    AST_ISSUE_ON_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we && !r_q.special) |-> (word_pos == ram_addr[POS_W-1:0])); // R3
    AST_SPECIAL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEEK && r_q.special) |-> ram_en); // R4
    AST_LOW_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we && !r_q.prev_track[TRACK_W-1]) |-> (ram_addr[ABS_W-1:LOC_W-1] == '0)); // R2
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we) |-> ($past(ram_en && !ram_we) && ram_addr == $past(ram_addr))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!busy && req_valid)); // R9
endmodule

// File: rtl/drum_access_ctrl.sv
`timescale 1ns/1ps
module drum_access_ctrl
    import drum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LOC_W-1:0]  req_addr,
    input  logic              req_we,
    input  logic              req_special,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_mask,
    output logic              req_ack,
    input  logic              ws_load,
    input  logic [WS_W-1:0]   ws_value,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic [POS_W-1:0]  word_pos,
    output logic [CNT_W-1:0]  cycle_cnt,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ABS_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    logic [WS_W-1:0]  ws_cur;
    logic [ABS_W-1:0] abs_addr;

    drum_word_clock u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_pos  (word_pos),
        .cycle_cnt (cycle_cnt)
    );

    drum_addr_map u_map (
        .loc      (req_addr),
        .ws       (ws_cur),
        .abs_addr (abs_addr)
    );

    drum_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_we      (req_we),
        .req_special (req_special),
        .req_wdata   (req_wdata),
        .req_mask    (req_mask),
        .req_ack     (req_ack),
        .ws_load     (ws_load),
        .ws_value    (ws_value),
        .ws_cur      (ws_cur),
        .abs_in      (abs_addr),
        .word_pos    (word_pos),
        .ram_en      (ram_en),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .ram_rdata   (ram_rdata),
        .done        (done),
        .rdata       (rdata),
        .busy        (busy)
    );
endmodule

// File: tb/drum_access_ctrl_tb.sv
`timescale 1ns/1ps
module drum_access_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  req_addr = '0;
    logic        req_we = 1'b0;
    logic        req_special = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_mask = '0;
    logic        req_ack;
    logic        ws_load = 1'b0;
    logic [3:0]  ws_value = '0;
    logic        done;
    logic [31:0] rdata;
    logic        busy;
    logic [4:0]  word_pos;
    logic [31:0] cycle_cnt;
    logic        ram_en, ram_we;
    logic [12:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    int checks = 0;
    int failures = 0;

    logic [31:0] ram_mem [2048];
    logic [31:0] exp_mem [2048];
    logic [4:0]  m_prev_track = '0;
    logic [3:0]  m_ws = 4'd1;

    always #2 clk = ~clk;

    drum_access_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_special(req_special), .req_wdata(req_wdata),
        .req_mask(req_mask), .req_ack(req_ack), .ws_load(ws_load),
        .ws_value(ws_value), .done(done), .rdata(rdata), .busy(busy),
        .word_pos(word_pos), .cycle_cnt(cycle_cnt), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) ram_mem[ram_addr[10:0]] <= ram_wdata;
            ram_rdata <= ram_mem[ram_addr[10:0]];
        end
    end

    function automatic logic [31:0] seed_word(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic load_ws(input logic [3:0] v);
        @(negedge clk);
        ws_load = 1'b1; ws_value = v;
        @(negedge clk);
        ws_load = 1'b0;
        m_ws = v;
    endtask

    // One access with independent expectations; optional ws_load while busy.
    task automatic run_access(input logic [9:0] a, input bit we, input bit sp,
                              input logic [31:0] wd, input logic [31:0] mk,
                              input string tag, input bit ws_mid,
                              input logic [3:0] ws_new);
        logic [4:0]  pos0, seek_pos, w;
        logic [31:0] c0, c1, lat, exp_lat, old;
        logic [12:0] abs_a;
        int          pen;
        bit          sp_eff, got;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_special = sp;
        req_wdata = wd; req_mask = mk;
        #1;
        pos0 = word_pos; c0 = cycle_cnt;
        check(req_ack == 1'b1, "R9", "ack when idle", 32'(req_ack), 32'd1);
        sp_eff = sp && !we;
        pen = (a[9:5] != m_prev_track) ? 6 : 0;
        m_prev_track = a[9:5];
        seek_pos = pos0 + 5'd1 + 5'(pen);
        w = sp_eff ? 5'd0 : (a[4:0] - seek_pos);
        exp_lat = 32'(3 + pen + int'(w));
        abs_a = a[9] ? {m_ws, a[8:0]} : {4'b0, a[8:0]};
        if (sp_eff) abs_a[4:0] = seek_pos;
        old = exp_mem[abs_a[10:0]];
        if (we) exp_mem[abs_a[10:0]] = (old & ~mk) | (wd & mk);
        @(negedge clk);
        check(req_ack == 1'b0, "R9", "no ack while busy", 32'(req_ack), 32'd0);
        req_valid = 1'b0;
        if (ws_mid) begin
            ws_load = 1'b1; ws_value = ws_new;
        end
        @(negedge clk);
        ws_load = 1'b0;
        if (ws_mid) m_ws = ws_new;
        got = 1'b0; c1 = '0;
        for (int k = 0; k < 80 && !got; k++) begin
            if (done) begin got = 1'b1; c1 = cycle_cnt; end
            else @(negedge clk);
        end
        lat = c1 - c0;
        check(got && lat == exp_lat, tag, "latency", lat, exp_lat);
        check(rdata == old, tag, "read data", rdata, old);
        @(negedge clk);
        check(done == 1'b0, "R9", "done single cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(word_pos == 5'd0, "R7", "pos in reset", 32'(word_pos), 0);
        check(cycle_cnt == 0, "R10", "count in reset", cycle_cnt, 0);
        check(!done && !busy && !req_ack, "R7", "idle in reset",
              {29'd0, done, busy, req_ack}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_word_clock();
        logic [4:0]  p;
        logic [31:0] c;
        bit ok_p = 1'b1, ok_c = 1'b1, wrapped = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            p = word_pos; c = cycle_cnt;
            @(negedge clk);
            if (word_pos != p + 5'd1) ok_p = 1'b0;
            if (p == 5'd31 && word_pos == 5'd0) wrapped = 1'b1;
            if (cycle_cnt != c + 32'd1) ok_c = 1'b0;
        end
        check(ok_p && wrapped, "R1", "position step and wrap", 32'(word_pos), 32'(p + 5'd1));
        check(ok_c, "R10", "cycle counter step", cycle_cnt, c + 1);
    endtask

    task automatic t_reset_group();  // R7 group 1 after reset, R2 relocation
        run_access(10'h205, 0, 0, 0, 0, "R7", 0, 0);
    endtask

    task automatic t_track_change(); // R5 penalty, R2 fixed group
        run_access(10'h045, 0, 0, 0, 0, "R5", 0, 0);
        run_access(10'h3E7, 0, 0, 0, 0, "R2", 0, 0);
    endtask

    task automatic t_same_track();   // R3 rotational wait only
        run_access(10'h3E1, 0, 0, 0, 0, "R3", 0, 0);
        run_access(10'h3FE, 0, 0, 0, 0, "R3", 0, 0);
    endtask

    task automatic t_special();      // R4 no rotational wait
        run_access(10'h3F0, 0, 1, 0, 0, "R4", 0, 0);
        run_access(10'h050, 0, 1, 0, 0, "R4", 0, 0);
        run_access(10'h048, 1, 1, 32'h12345678, 32'hFFFFFFFF, "R4", 0, 0);
        run_access(10'h048, 0, 0, 0, 0, "R4", 0, 0);
    endtask

    task automatic t_masked_write(); // R6 merge under mask
        run_access(10'h210, 1, 0, 32'hDEADBEEF, 32'h00FF00FF, "R6", 0, 0);
        run_access(10'h210, 0, 0, 0, 0, "R6", 0, 0);
        run_access(10'h211, 1, 0, 32'hFFFFFFFF, 32'h00000000, "R6", 0, 0);
        run_access(10'h211, 0, 0, 0, 0, "R6", 0, 0);
    endtask

    task automatic t_ws_switch();    // R8 group change timing
        load_ws(4'd2);
        run_access(10'h203, 0, 0, 0, 0, "R8", 0, 0);
        run_access(10'h20A, 0, 0, 0, 0, "R8", 1, 4'd3);
        run_access(10'h20B, 0, 0, 0, 0, "R8", 0, 0);
        run_access(10'h20B, 1, 0, 32'hA5A5A5A5, 32'hF0F0F0F0, "R8", 0, 0);
        load_ws(4'd1);
        run_access(10'h20B, 0, 0, 0, 0, "R8", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin
            ram_mem[i] = seed_word(i);
            exp_mem[i] = seed_word(i);
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_word_clock();
        t_reset_group();
        t_track_change();
        t_same_track();
        t_special();
        t_masked_write();
        t_ws_switch();
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        summary();
    end
endmodule